// File: doc/BRIEF.md
# PCM Highway Frame Timing Generator

This block derives all frame-level timing for a time-division voice highway from a single bit clock. With the intended 2.048 MHz input, a 256-step frame counter closes one frame every 125 µs (8 kHz). Three groups of outputs come from this one counter, so they always hold the same phase relationship. The first group is a ladder of five square-wave channel-select lines at 128, 64, 32, 16 and 8 kHz. The second is eight one-hot timeslot pulses. The third is six single-clock codec sync strobes.

Every output is the registered decode of the counter value. The outputs therefore change only on a clock edge and carry no decode glitches. The registers lag the counter by one cycle. A synchronous reset returns the counter to zero and parks all outputs low. The first enabled clock after reset then presents slot 0 of a fresh frame. Dropping the enable freezes the counter and every output together, so the timing resumes where it stopped.

Top module: `hwy_frame_timer`

## Requirements
- R1: While `rst_i` is high at a clock edge, and after it until the first enabled edge, every bit of `sel_o`, `chan_o` and `sync_o` is 0.
- R2: Number the enabled edges since reset n = 1, 2, … and let phase p = (n−1) mod 256. After enabled edge n, `sel_o[i]` (i = 0..4) equals 1 exactly when bit (3+i) of p is 0. This gives `sel_o[0]` a 16-clock period (128 kHz), and each higher bit a period twice as long. `sel_o[4]` is high for the first half of the frame.
- R3: After enabled edge n, `chan_o` is one-hot with bit floor(p/32) set. Each slot lasts 32 clocks, and the slots run in order from 0 to 7.
- R4: After enabled edge n, `sync_o[k]` (k = 0..5) is 1 only when p = 32·k. It is one clock wide, it falls inside `chan_o[k]`, and at most one sync bit is high at a time. No sync fires in slots 6 and 7.
- R5: The pattern repeats every 256 enabled clocks. Phase 255 is followed by phase 0, which has `chan_o[0]` high and all five selects high.
- R6: On a clock edge with `en_i` low (and `rst_i` low), the counter and all outputs hold their values. Counting resumes from the same phase when `en_i` returns high.
- R7: A reset taken in the middle of a frame restarts timing. The first enabled edge after it shows phase 0, whatever phase was running before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock (2.048 MHz nominal) |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Count enable; low freezes all timing |
| sel_o | output | 5 | Channel-select ladder, bit 0 fastest (128 kHz) to bit 4 (8 kHz) |
| sync_o | output | 6 | Codec frame syncs, bit k pulses at the start of slot k |
| chan_o | output | 8 | One-hot timeslot pulses, bit s high during slot s |

## Verification
A corrupted frame counter appears at the ports on the very next enabled edge. The select ladder then shows a phase that disagrees with the bench's phase model, and no later frame brings it back into step. Decode faults show up differently. A bad slot compare produces a `chan_o` that is not one-hot, or a pulse in the wrong slot, within at most 32 clocks. A bad zero-offset compare makes a sync strobe early, late or twice, within one frame of 256 clocks. Enable and reset faults are caught on the first frozen or restarted cycle, because every cycle is compared against the model.

// File: rtl/hwy_pkg.sv
package hwy_pkg;
    // Default geometry of the timing generator
    localparam int unsigned HWY_CNT_W     = 8;  // 256 bit clocks per frame
    localparam int unsigned HWY_NUM_SEL   = 5;  // select ladder taps
    localparam int unsigned HWY_NUM_SLOTS = 8;  // timeslots per frame
    localparam int unsigned HWY_NUM_SYNC  = 6;  // codec sync strobes
endpackage

// File: rtl/hwy_frame_cnt.sv
module hwy_frame_cnt #(
    parameter int unsigned CNT_W = hwy_pkg::HWY_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R5: enabled edge advances exactly one step, wrapping at frame end
    p_count_step_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));

    // R6: disabled edge leaves the frame counter alone
    p_count_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/hwy_sel_ladder.sv
module hwy_sel_ladder #(
    parameter int unsigned NUM_SEL = hwy_pkg::HWY_NUM_SEL
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [NUM_SEL-1:0] tap_i,   // upper counter bits, LSB = fastest
    output logic [NUM_SEL-1:0] sel_o
);
    typedef struct packed {
        logic [NUM_SEL-1:0] sel;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic [NUM_SEL-1:0] sel_dec;

    // Each select is high in the lower half of its own counter bit's cycle
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_tap
        assign sel_dec[i] = ~tap_i[i];
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.sel = sel_dec;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

    // R2: the slowest select only rises at frame start, where all selects are high
    p_frame_start_all_high_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sel_o[NUM_SEL-1]) |-> (&sel_o));

    // R6: selects frozen while disabled
    p_sel_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(sel_o));
endmodule

// File: rtl/hwy_slot_decode.sv
module hwy_slot_decode #(
    parameter int unsigned CNT_W     = hwy_pkg::HWY_CNT_W,
    parameter int unsigned NUM_SLOTS = hwy_pkg::HWY_NUM_SLOTS,
    parameter int unsigned NUM_SYNC  = hwy_pkg::HWY_NUM_SYNC
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic [CNT_W-1:0]     cnt_i,
    output logic [NUM_SLOTS-1:0] chan_o,
    output logic [NUM_SYNC-1:0]  sync_o
);
    localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS);
    localparam int unsigned OFFSET_W = CNT_W - SLOT_W;

    typedef struct packed {
        logic [NUM_SLOTS-1:0] chan;
        logic [NUM_SYNC-1:0]  sync;
    } slot_st_t;

    slot_st_t st_d, st_q;

    logic [SLOT_W-1:0]    slot_idx;
    logic                 slot_head;
    logic [NUM_SLOTS-1:0] chan_dec;
    logic [NUM_SYNC-1:0]  sync_dec;

    assign slot_idx  = cnt_i[CNT_W-1 -: SLOT_W];
    assign slot_head = (cnt_i[OFFSET_W-1:0] == '0);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chan
        assign chan_dec[s] = (slot_idx == SLOT_W'(s));
    end

    for (genvar k = 0; k < NUM_SYNC; k++) begin : g_sync
        assign sync_dec[k] = slot_head & chan_dec[k];
    end

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.chan = chan_dec;
            st_d.sync = sync_dec;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_o = st_q.chan;
    assign sync_o = st_q.sync;

    // R3: never two timeslot pulses at once
    p_chan_onehot0_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(chan_o));

    // R4: at most one codec strobe at a time
    p_sync_onehot0_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(sync_o));

    // R4: a codec strobe only inside its own timeslot
    p_sync_in_slot_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        ((sync_o & ~chan_o[NUM_SYNC-1:0]) == '0));

    // R6: decode outputs frozen while disabled
    p_slot_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(chan_o) && $stable(sync_o)));
endmodule

// File: rtl/hwy_frame_timer.sv
module hwy_frame_timer #(
    parameter int unsigned CNT_W     = hwy_pkg::HWY_CNT_W,
    parameter int unsigned NUM_SEL   = hwy_pkg::HWY_NUM_SEL,
    parameter int unsigned NUM_SLOTS = hwy_pkg::HWY_NUM_SLOTS,
    parameter int unsigned NUM_SYNC  = hwy_pkg::HWY_NUM_SYNC
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    output logic [NUM_SEL-1:0]   sel_o,
    output logic [NUM_SYNC-1:0]  sync_o,
    output logic [NUM_SLOTS-1:0] chan_o
);
    logic [CNT_W-1:0] frame_cnt;

    hwy_frame_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .cnt_o (frame_cnt)
    );

    hwy_sel_ladder #(
        .NUM_SEL (NUM_SEL)
    ) u_sel (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .en_i  (en_i),
        .tap_i (frame_cnt[CNT_W-1 -: NUM_SEL]),
        .sel_o (sel_o)
    );

    hwy_slot_decode #(
        .CNT_W     (CNT_W),
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SYNC  (NUM_SYNC)
    ) u_slot (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (en_i),
        .cnt_i  (frame_cnt),
        .chan_o (chan_o),
        .sync_o (sync_o)
    );

    // R7: cycle after a reset edge shows idle outputs
    p_reset_idle_r7: assert property (@(posedge clk_i)
        rst_i |=> ((sel_o == '0) && (chan_o == '0) && (sync_o == '0)));
endmodule

// File: tb/tb_hwy_frame_timer.sv
module tb_hwy_frame_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [4:0] sel;
    logic [5:0] sync;
    logic [7:0] chan;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hwy_frame_timer dut (
        .clk_i  (clk),
        .rst_i  (rst),
        .en_i   (en),
        .sel_o  (sel),
        .sync_o (sync),
        .chan_o (chan)
    );

    typedef struct {
        logic [4:0] sel;
        logic [7:0] chan;
        logic [5:0] sync;
        int         t_sel;
        int         t_chan;
        int         t_sync;
    } exp_t;

    exp_t exp_q[$];

    // bench model state
    int   m_ph   = 0;    // next phase to present
    int   m_wraps = 0;
    bit   m_restart = 1'b0;
    exp_t m_last;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    // one clock of stimulus; expected output after the coming edge is queued
    task automatic step(input bit r, input bit e);
        exp_t x;
        @(negedge clk);
        rst = r;
        en  = e;
        if (r) begin
            m_ph = 0; m_wraps = 0;
            x.sel = '0; x.chan = '0; x.sync = '0;
            x.t_sel = 1; x.t_chan = 1; x.t_sync = 1;
            m_last = x;
        end else if (!e) begin
            x = m_last;
            x.t_sel = 6; x.t_chan = 6; x.t_sync = 6;
        end else begin
            for (int i = 0; i < 5; i++) x.sel[i] = ((m_ph >> (3 + i)) & 1) == 0;
            x.chan = 8'(1 << (m_ph / 32));
            x.sync = ((m_ph % 32) == 0 && (m_ph / 32) < 6) ? 6'(1 << (m_ph / 32)) : 6'd0;
            x.t_sel = 2; x.t_chan = 3; x.t_sync = 4;
            if (m_ph == 0 && m_wraps > 0) begin x.t_chan = 5; x.t_sel = 5; end
            if (m_restart && m_ph == 0) begin x.t_chan = 7; x.t_sel = 7; x.t_sync = 7; m_restart = 1'b0; end
            m_last = x;
            m_ph = m_ph + 1;
            if (m_ph == 256) begin m_ph = 0; m_wraps++; end
        end
        exp_q.push_back(x);
    endtask

    // monitor: compare away from the edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_checks += 3;
            if (sel !== x.sel) begin
                n_errors++;
                $display("FAIL %s sel actual=%b expected=%b", tag_name(x.t_sel), sel, x.sel);
            end
            if (chan !== x.chan) begin
                n_errors++;
                $display("FAIL %s chan actual=%b expected=%b", tag_name(x.t_chan), chan, x.chan);
            end
            if (sync !== x.sync) begin
                n_errors++;
                $display("FAIL %s sync actual=%b expected=%b", tag_name(x.t_sync), sync, x.sync);
            end
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        // R1: idle after reset until enabled
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        // R2 R3 R4 R5: two full frames plus a bit, free running
        for (int i = 0; i < 600; i++) step(1'b0, 1'b1);
        // R6: gated enable pattern, freezes interleaved
        for (int i = 0; i < 400; i++) step(1'b0, (i % 7) != 3 && (i % 11) != 5);
        // R7: mid-frame reset and restart
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1);
        m_restart = 1'b1;
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule